// File: doc/BRIEF.md
# Router Switch Allocator with Packet Hold

This block decides, once per cycle, which flits cross the crossbar of an input-queued virtual-channel router. Each input offers many VCs. Each input first chooses one candidate VC, scanning round-robin from an offset it keeps for itself. The outputs then arbitrate among the inputs that target them, each output using its own round-robin pointer. The result is a separable allocation: every input and every output receives at most one grant per cycle. The grant, the crossbar selects and a credit strobe toward the upstream router are all registered. They appear one cycle after the request pattern they answer.

An optional hold mode keeps an input-output connection for a whole packet. In hold mode, a grant on a non-tail flit locks the input, its VC and the output. While the lock stands, the locked VC forwards without arbitration whenever it has a flit and downstream space, and the held input and output take part in no new arbitration. Forwarding the tail flit releases the lock. Speedup is 1 on both sides.

Top module: `sa_switch_alloc`

## Requirements
- R1: A VC is a candidate only when `vc_active_i` is 1, `vc_empty_i` is 0 and `vc_dfull_i` is 0 for it. VC v of input i uses flat index i*N_VC+v in every per-VC port.
- R2: Each input scans its VCs starting from a stored offset, wrapping modulo N_VC, and picks the first candidate. After the input forwards VC v, its offset becomes (v+1) mod N_VC. All offsets reset to 0.
- R3: When several inputs pick the same output, that output grants the first of them found scanning from its pointer, wrapping modulo N_IN. After such a grant the pointer becomes winner+1. Pointers reset to 0.
- R4: Per cycle, at most one grant exists per input and per output. `xbar_valid_o[o]` is 1 exactly for outputs receiving a flit, and `xbar_sel_o[o]` holds the input number sent to output o.
- R5: Grant, crossbar and credit outputs are registered. They reflect the requests of the previous cycle and are all 0 after reset.
- R6: Each forwarded flit raises `cred_valid_o[i]` for its input, with `cred_vc_o[i]` equal to the VC it left.
- R7: With `hold_en_i` at 1, a forwarded flit whose `vc_tail_i` is 0 locks its input, VC and output. In later cycles the locked VC is forwarded to the locked output without arbitration. The locked input makes no new request, and no other input is granted the locked output.
- R8: In a cycle where the locked VC is empty or its downstream VC is full, nothing is forwarded on that input. The lock remains.
- R9: Forwarding a flit with `vc_tail_i` at 1 releases the lock on its input and output.
- R10: With `hold_en_i` at 0, grants create no lock. Each cycle is arbitrated afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_en_i | input | 1 | Enables packet hold on new grants |
| vc_active_i | input | N_IN*N_VC | VC owns an output VC |
| vc_empty_i | input | N_IN*N_VC | VC buffer is empty |
| vc_dfull_i | input | N_IN*N_VC | Downstream VC has no space |
| vc_tail_i | input | N_IN*N_VC | Front flit of VC is a tail |
| vc_port_i | input | N_IN*N_VC x clog2(N_OUT) | Output port of each VC |
| gnt_valid_o | output | N_IN | Input forwarded a flit |
| gnt_vc_o | output | N_IN x clog2(N_VC) | VC forwarded per input |
| xbar_valid_o | output | N_OUT | Output receives a flit |
| xbar_sel_o | output | N_OUT x clog2(N_IN) | Input selected per output |
| cred_valid_o | output | N_IN | Credit toward upstream router |
| cred_vc_o | output | N_IN x clog2(N_VC) | VC id carried by the credit |

## Verification
Two functions can fall in the same cycle: a locked connection forwarding without arbitration, and a competing input whose request for that output must be refused. A further case in the same cycle is the release of a lock by a tail flit while another input waits on that output. The bench holds a second input requesting the locked output across the whole packet, including the cycle where the locked VC drains. It judges that this input gains the output only in the cycle after the tail leaves, with the output pointer value that was left over from the first arbitration.

// File: rtl/sa_pkg.sv
package sa_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sa_rr_pick.sv
module sa_rr_pick #(
  parameter int W  = 4,
  parameter int IW = sa_pkg::idx_w(W)
) (
  input  logic [W-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < W; k++) begin
      int p;
      p = int'(ptr_i) + k;
      if (p >= W) p = p - W;
      if (!any_o && req_i[p]) begin
        any_o = 1'b1;
        idx_o = IW'(p);
      end
    end
  end
endmodule

// File: rtl/sa_hold_state.sv
module sa_hold_state #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_VC  = 4,
  localparam int OW = sa_pkg::idx_w(N_OUT),
  localparam int VW = sa_pkg::idx_w(N_VC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      hold_en_i,
  input  logic [N_IN-1:0]           fwd_i,
  input  logic [N_IN-1:0]           fwd_tail_i,
  input  logic [N_IN-1:0][VW-1:0]   fwd_vc_i,
  input  logic [N_IN-1:0][OW-1:0]   fwd_port_i,
  output logic [N_IN-1:0]           hold_vld_o,
  output logic [N_IN-1:0][VW-1:0]   hold_vc_o,
  output logic [N_OUT-1:0]          out_held_o
);
  logic [N_IN-1:0][OW-1:0] hold_port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_o  <= '0;
      hold_vc_o   <= '0;
      hold_port_q <= '0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        if (fwd_i[i]) begin
          if (fwd_tail_i[i]) begin
            hold_vld_o[i] <= 1'b0;
          end else if (hold_en_i || hold_vld_o[i]) begin
            hold_vld_o[i]  <= 1'b1;
            hold_vc_o[i]   <= fwd_vc_i[i];
            hold_port_q[i] <= fwd_port_i[i];
          end
        end
      end
    end
  end

  // output lock derived from input locks: one source of truth
  always_comb begin
    out_held_o = '0;
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++)
        if (hold_vld_o[i] && hold_port_q[i] == OW'(o)) out_held_o[o] = 1'b1;
  end
endmodule

// File: rtl/sa_switch_alloc.sv
module sa_switch_alloc #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_VC  = 4,
  localparam int NV = N_IN * N_VC,
  localparam int IW = sa_pkg::idx_w(N_IN),
  localparam int OW = sa_pkg::idx_w(N_OUT),
  localparam int VW = sa_pkg::idx_w(N_VC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     hold_en_i,
  input  logic [NV-1:0]            vc_active_i,
  input  logic [NV-1:0]            vc_empty_i,
  input  logic [NV-1:0]            vc_dfull_i,
  input  logic [NV-1:0]            vc_tail_i,
  input  logic [NV-1:0][OW-1:0]    vc_port_i,
  output logic [N_IN-1:0]          gnt_valid_o,
  output logic [N_IN-1:0][VW-1:0]  gnt_vc_o,
  output logic [N_OUT-1:0]         xbar_valid_o,
  output logic [N_OUT-1:0][IW-1:0] xbar_sel_o,
  output logic [N_IN-1:0]          cred_valid_o,
  output logic [N_IN-1:0][VW-1:0]  cred_vc_o
);
  logic [N_IN-1:0][VW-1:0]   in_off_q;
  logic [N_OUT-1:0][IW-1:0]  out_ptr_q;
  logic [N_IN-1:0]           hold_vld;
  logic [N_IN-1:0][VW-1:0]   hold_vc;
  logic [N_OUT-1:0]          out_held;

  logic [N_IN-1:0][N_VC-1:0] cand;
  logic [N_IN-1:0]           pick_any;
  logic [N_IN-1:0][VW-1:0]   pick_vc;
  logic [N_IN-1:0][OW-1:0]   pick_port;
  logic [N_OUT-1:0][N_IN-1:0] oreq;
  logic [N_OUT-1:0]          win_any;
  logic [N_OUT-1:0][IW-1:0]  win_in;

  logic [N_IN-1:0]           fwd, fwd_tail;
  logic [N_IN-1:0][VW-1:0]   fwd_vc;
  logic [N_IN-1:0][OW-1:0]   fwd_port;
  logic [N_OUT-1:0]          xb_vld;
  logic [N_OUT-1:0][IW-1:0]  xb_sel;

  // stage 1: one candidate VC per input
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    always_comb begin
      for (int v = 0; v < N_VC; v++) begin
        int f;
        f = i * N_VC + v;
        cand[i][v] = vc_active_i[f] && !vc_empty_i[f] && !vc_dfull_i[f] &&
                     !out_held[vc_port_i[f]] && !hold_vld[i];
      end
    end

    sa_rr_pick #(.W(N_VC), .IW(VW)) u_vc_pick (
      .req_i (cand[i]),
      .ptr_i (in_off_q[i]),
      .any_o (pick_any[i]),
      .idx_o (pick_vc[i])
    );

    assign pick_port[i] = vc_port_i[i * N_VC + int'(pick_vc[i])];
  end

  // stage 2: one input per output
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    always_comb begin
      for (int i = 0; i < N_IN; i++)
        oreq[o][i] = pick_any[i] && (pick_port[i] == OW'(o));
    end

    sa_rr_pick #(.W(N_IN), .IW(IW)) u_in_pick (
      .req_i (oreq[o]),
      .ptr_i (out_ptr_q[o]),
      .any_o (win_any[o]),
      .idx_o (win_in[o])
    );
  end

  // merge held connections with fresh grants
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      logic held_go, new_go;
      int hf;
      hf      = i * N_VC + int'(hold_vc[i]);
      held_go = hold_vld[i] && !vc_empty_i[hf] && !vc_dfull_i[hf];
      new_go  = pick_any[i] && win_any[pick_port[i]] && (win_in[pick_port[i]] == IW'(i));
      fwd[i]      = held_go || new_go;
      fwd_vc[i]   = hold_vld[i] ? hold_vc[i] : pick_vc[i];
      fwd_port[i] = vc_port_i[i * N_VC + int'(fwd_vc[i])];
      fwd_tail[i] = vc_tail_i[i * N_VC + int'(fwd_vc[i])];
    end
  end

  always_comb begin
    xb_vld = '0;
    xb_sel = '0;
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++)
        if (fwd[i] && fwd_port[i] == OW'(o)) begin
          xb_vld[o] = 1'b1;
          xb_sel[o] = IW'(i);
        end
  end

  sa_hold_state #(.N_IN(N_IN), .N_OUT(N_OUT), .N_VC(N_VC)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_en_i  (hold_en_i),
    .fwd_i      (fwd),
    .fwd_tail_i (fwd_tail),
    .fwd_vc_i   (fwd_vc),
    .fwd_port_i (fwd_port),
    .hold_vld_o (hold_vld),
    .hold_vc_o  (hold_vc),
    .out_held_o (out_held)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_off_q     <= '0;
      out_ptr_q    <= '0;
      gnt_valid_o  <= '0;
      gnt_vc_o     <= '0;
      xbar_valid_o <= '0;
      xbar_sel_o   <= '0;
      cred_valid_o <= '0;
      cred_vc_o    <= '0;
    end else begin
      gnt_valid_o  <= fwd;
      gnt_vc_o     <= fwd_vc;
      xbar_valid_o <= xb_vld;
      xbar_sel_o   <= xb_sel;
      cred_valid_o <= fwd;
      cred_vc_o    <= fwd_vc;
      for (int i = 0; i < N_IN; i++)
        if (fwd[i])
          in_off_q[i] <= (int'(fwd_vc[i]) == N_VC - 1) ? '0 : fwd_vc[i] + VW'(1);
      for (int o = 0; o < N_OUT; o++)
        if (win_any[o])
          out_ptr_q[o] <= (int'(win_in[o]) == N_IN - 1) ? '0 : win_in[o] + IW'(1);
    end
  end
endmodule

// File: rtl/sa_switch_alloc_chk.sv
module sa_switch_alloc_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_VC  = 4,
  localparam int NV = N_IN * N_VC,
  localparam int IW = sa_pkg::idx_w(N_IN),
  localparam int VW = sa_pkg::idx_w(N_VC)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NV-1:0]            vc_empty_i,
  input logic [NV-1:0]            vc_dfull_i,
  input logic [N_IN-1:0]          gnt_valid_o,
  input logic [N_IN-1:0][VW-1:0]  gnt_vc_o,
  input logic [N_OUT-1:0]         xbar_valid_o,
  input logic [N_OUT-1:0][IW-1:0] xbar_sel_o,
  input logic [N_IN-1:0]          cred_valid_o,
  input logic [N_IN-1:0][VW-1:0]  cred_vc_o
);
  logic [NV-1:0] emp_q, dfull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emp_q   <= '1;
      dfull_q <= '1;
    end else begin
      emp_q   <= vc_empty_i;
      dfull_q <= vc_dfull_i;
    end
  end

  // R4
  grant_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(xbar_valid_o) == $countones(gnt_valid_o));

  for (genvar i = 0; i < N_IN; i++) begin : g_i
    // R1
    granted_vc_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_valid_o[i] |-> (!emp_q[i * N_VC + int'(gnt_vc_o[i])] &&
                          !dfull_q[i * N_VC + int'(gnt_vc_o[i])]));
    // R6
    credit_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cred_valid_o[i] == gnt_valid_o[i]) &&
      (!cred_valid_o[i] || cred_vc_o[i] == gnt_vc_o[i]));
  end

  for (genvar a = 0; a < N_OUT; a++) begin : g_a
    // R4
    sel_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xbar_valid_o[a] |-> gnt_valid_o[xbar_sel_o[a]]);
    for (genvar b = a + 1; b < N_OUT; b++) begin : g_b
      // R4
      sel_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xbar_valid_o[a] && xbar_valid_o[b]) |-> (xbar_sel_o[a] != xbar_sel_o[b]));
    end
  end
endmodule

bind sa_switch_alloc sa_switch_alloc_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_VC(N_VC)) chk_i (.*);

// File: tb/sa_switch_alloc_tb_top.sv
module sa_switch_alloc_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hold_en_i = 1'b0;
  logic [15:0] vc_active_i = '0, vc_empty_i = '1, vc_dfull_i = '0, vc_tail_i = '1;
  logic [15:0][1:0] vc_port_i = '0;
  logic [3:0] gnt_valid_o, xbar_valid_o, cred_valid_o;
  logic [3:0][1:0] gnt_vc_o, xbar_sel_o, cred_vc_o;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sa_switch_alloc dut_i (.*);

  typedef struct packed {
    logic [15:0] req;
    logic [31:0] port;
    logic [3:0]  ev;
    logic [7:0]  evc;
  } vec_t;

  localparam int NSTEP = 6;
  localparam vec_t TBL [NSTEP] = '{
    '{16'h1111, 32'h0,        4'b0001, 8'h00},
    '{16'h1111, 32'h0,        4'b0010, 8'h00},
    '{16'hFFFF, 32'hE4E4E4E4, 4'b0101, 8'h01},
    '{16'hFFFF, 32'hE4E4E4E4, 4'b1011, 8'h06},
    '{16'h0801, 32'hE4E4E4E4, 4'b0101, 8'h30},
    '{16'h0000, 32'hE4E4E4E4, 4'b0000, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_vc(input logic [7:0] v, input logic [3:0] m);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) r[2*i +: 2] = m[i] ? v[2*i +: 2] : 2'b00;
    return r;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    hold_en_i = 1'b0;
    vc_active_i = '0; vc_empty_i = '1; vc_dfull_i = '0; vc_tail_i = '1; vc_port_i = '0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    do_reset();
    // R5: reset state
    chk("R5 reset gnt", 32'(gnt_valid_o), 0);
    chk("R5 reset xbar", 32'(xbar_valid_o), 0);
    chk("R5 reset cred", 32'(cred_valid_o), 0);

    // R2 R3 R4 R6: table walk, non-hold traffic
    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk_i);
      vc_active_i = TBL[s].req;
      vc_empty_i  = ~TBL[s].req;
      vc_port_i   = TBL[s].port;
      tick();
      chk($sformatf("R2/R3 step%0d gnt_valid", s), 32'(gnt_valid_o), 32'(TBL[s].ev));
      chk($sformatf("R2/R3 step%0d gnt_vc", s), 32'(mask_vc(gnt_vc_o, gnt_valid_o)), 32'(TBL[s].evc));
      chk($sformatf("R6 step%0d cred_valid", s), 32'(cred_valid_o), 32'(TBL[s].ev));
      chk($sformatf("R6 step%0d cred_vc", s), 32'(mask_vc(cred_vc_o, cred_valid_o)), 32'(TBL[s].evc));
      chk($sformatf("R4 step%0d xbar count", s), $countones(xbar_valid_o), $countones(TBL[s].ev));
    end

    // R1: eligibility, R5: registered timing
    do_reset();
    @(negedge clk_i);
    vc_active_i = 16'h0003;
    vc_empty_i  = 16'hFFFA;
    vc_dfull_i  = 16'h0001;
    tick();
    chk("R1 no eligible VC", 32'(gnt_valid_o), 0);
    @(negedge clk_i);
    vc_dfull_i = 16'h0000;
    #1;
    chk("R5 not yet granted", 32'(gnt_valid_o), 0);
    tick();
    chk("R1 eligible after space", 32'(gnt_valid_o), 32'h1);
    chk("R1 eligible vc", 32'(gnt_vc_o[0]), 0);

    // R7 R8 R9 R4: hold mode
    do_reset();
    @(negedge clk_i);
    hold_en_i = 1'b1;
    vc_port_i[1] = 2'd2;
    vc_port_i[0] = 2'd3;
    vc_port_i[4] = 2'd2;
    vc_active_i = 16'h0012;
    vc_empty_i  = ~16'h0013;
    vc_tail_i   = 16'hFFFD;
    tick();
    chk("R7 first grant", 32'(gnt_valid_o), 32'h1);
    chk("R7 first vc", 32'(gnt_vc_o[0]), 1);
    chk("R4 first xbar", 32'(xbar_valid_o), 32'h4);
    chk("R4 first sel", 32'(xbar_sel_o[2]), 0);
    @(negedge clk_i);
    vc_active_i = 16'h0013;
    tick();
    chk("R7 held forward", 32'(gnt_valid_o), 32'h1);
    chk("R7 held vc", 32'(gnt_vc_o[0]), 1);
    @(negedge clk_i);
    vc_empty_i = ~16'h0011;
    tick();
    chk("R8 held empty cancels", 32'(gnt_valid_o), 0);
    chk("R8 no xbar", 32'(xbar_valid_o), 0);
    @(negedge clk_i);
    vc_empty_i = ~16'h0013;
    vc_tail_i  = 16'hFFFF;
    tick();
    chk("R9 tail forward", 32'(gnt_valid_o), 32'h1);
    chk("R9 tail vc", 32'(gnt_vc_o[0]), 1);
    @(negedge clk_i);
    vc_active_i = 16'h0011;
    vc_empty_i  = ~16'h0011;
    tick();
    chk("R9 released grants", 32'(gnt_valid_o), 32'h3);
    chk("R9 released vcs", 32'(mask_vc(gnt_vc_o, gnt_valid_o)), 0);
    chk("R4 xbar outputs", 32'(xbar_valid_o), 32'hC);
    chk("R4 sel out2", 32'(xbar_sel_o[2]), 1);
    chk("R4 sel out3", 32'(xbar_sel_o[3]), 0);
    chk("R6 credit vc in1", 32'(cred_vc_o[1]), 0);

    // R10: no lock without hold enable
    do_reset();
    @(negedge clk_i);
    vc_port_i[1] = 2'd2;
    vc_port_i[4] = 2'd2;
    vc_active_i = 16'h0012;
    vc_empty_i  = ~16'h0012;
    vc_tail_i   = 16'hFFFD;
    tick();
    chk("R10 first grant", 32'(gnt_valid_o), 32'h1);
    tick();
    chk("R10 rearbitrated", 32'(gnt_valid_o), 32'h2);
    chk("R10 winner vc", 32'(gnt_vc_o[1]), 0);

    done = 1;
    summary();
  end
endmodule